// File: doc/BRIEF.md
# Generalized Bit Reverse and OR-Combine Unit

This block is a 32-bit permutation and merge datapath. It takes one data operand and a 5-bit control value, and it runs the operand through a five-level butterfly network. Each control bit enables one level. Level `s` pairs bit groups of width `2^s`.

In reverse mode an enabled level swaps each pair of neighbouring groups. In OR-combine mode an enabled level ORs each group into its partner, and it also keeps the original bits. Every familiar setting comes out of the same network for a matching control value: full bit reversal, byte-order swap, byte OR-combine and halfword OR-combine. No setting has its own special logic.

The control value is the low five bits of a second operand. An optional output register is loaded under an input valid strobe. The register raises an output valid one cycle after the strobe.

Top module: `gbr_unit`

## Requirements
- R1: Only bits [4:0] of `operandB` steer the network. Bits [31:5] have no effect on `result`.
- R2: With `opSel` = 0 (reverse), the result is the result of levels 0 to 4 applied in ascending order. An enabled level `s` exchanges each group of `2^s` bits with its neighbouring group of the same width. In bit-index terms, `result[i] = operandA[i XOR ctrl]`, and the ones count of the operand is preserved.
- R3: With `opSel` = 1 (OR-combine), each enabled level ORs the current value with its group-swapped copy. In bit-index terms, `result[i]` is the OR of `operandA[i XOR m]` over every `m` whose set bits are a subset of `ctrl`. Every bit set in the operand remains set.
- R4: A control value of 0 returns `operandA` unchanged in both modes.
- R5: Reverse with control 5'b11111 yields the full 32-bit bit reversal of the operand.
- R6: Reverse with control 5'b11000 yields the byte-order swap of the operand.
- R7: OR-combine with control 5'b00111 sets every bit of each byte to the OR of that byte's eight input bits.
- R8: OR-combine with control 5'b10000 puts the OR of the two input halfwords into both halves of the result.
- R9: With the output register enabled (default), `result` takes the value computed from the inputs seen at a rising edge where `inValid` = 1. At an edge where `inValid` = 0, `result` keeps its value.
- R10: `outValid` equals the `inValid` value from the previous rising edge. While `rstN` is low, `result` and `outValid` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: load the network output this edge |
| opSel | input | 1 | 0 = reverse, 1 = OR-combine |
| operandA | input | 32 | Data operand |
| operandB | input | 32 | Control source; only bits [4:0] are used |
| result | output | 32 | Network output (registered by default) |
| outValid | output | 1 | Result valid, one cycle after `inValid` |

## Verification
The network holds no state, so an error in any level shows up in `result` one clock after the operand is loaded. Wrong level masks, swapped shift directions and a wrong level order each corrupt only a subset of the 32 control values. Sweeping all of them in both modes against a bit-index model exposes the error on the first operand that has a bit in an affected group. A fault in the output register or in the valid flop shows up in the cycle that follows the first strobe. It also shows up in the first idle cycle, where the held value or a low `outValid` is expected.

// File: rtl/gbr_pkg.sv
package gbr_pkg;

  localparam int DATA_W = 32;

  typedef enum logic {
    OP_REVERSE = 1'b0,
    OP_ORCOMB  = 1'b1
  } gbrOp_e;

  // strobes from control to datapath; width of stageEn fixed by DATA_W
  typedef struct packed {
    logic [$clog2(DATA_W)-1:0] stageEn;
    logic                      orMode;
    logic                      load;
  } gbrStrobe_t;

endpackage

// File: rtl/gbr_ctrl.sv
module gbr_ctrl
  import gbr_pkg::*;
#(
  parameter int DATA_W = gbr_pkg::DATA_W
) (
  input  logic                      inValid,
  input  logic                      opSel,
  input  logic [$clog2(DATA_W)-1:0] ctrlAmt,
  output gbrStrobe_t                strobe
);

  gbrOp_e opKind;

  always_comb begin
    opKind         = gbrOp_e'(opSel);
    strobe.stageEn = ctrlAmt;
    strobe.orMode  = (opKind == OP_ORCOMB);
    strobe.load    = inValid;
  end

endmodule

// File: rtl/gbr_datapath.sv
module gbr_datapath
  import gbr_pkg::*;
#(
  parameter int DATA_W  = gbr_pkg::DATA_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  gbrStrobe_t        strobe,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              outValid
);

  localparam int STAGE_N = $clog2(DATA_W);

  // bit i belongs to the lower group of its pair at level s when bit s of i is 0
  function automatic logic [DATA_W-1:0] lowMask(input int s);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> s) & 1) == 0;
    return m;
  endfunction

  logic [DATA_W-1:0] stageVal [STAGE_N+1];
  logic [DATA_W-1:0] netOut;

  assign stageVal[0] = operand;

  for (genvar s = 0; s < STAGE_N; s++) begin : gLevel
    localparam int                SHIFT = 1 << s;
    localparam logic [DATA_W-1:0] LO    = lowMask(s);
    localparam logic [DATA_W-1:0] HI    = ~LO;
    logic [DATA_W-1:0] swapped;
    assign swapped = ((stageVal[s] & LO) << SHIFT) | ((stageVal[s] & HI) >> SHIFT);
    assign stageVal[s+1] = !strobe.stageEn[s] ? stageVal[s]
                         : strobe.orMode      ? (stageVal[s] | swapped)
                         :                      swapped;
  end

  assign netOut = stageVal[STAGE_N];

  // R4
  always_comb begin
    if (rstN && strobe.stageEn == '0) begin
      passthru_chk: assert (netOut == operand);
    end
  end

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        result   <= '0;
        outValid <= 1'b0;
      end else begin
        outValid <= strobe.load;
        if (strobe.load) result <= netOut;
      end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load |=> $stable(result));
    // R10
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load |=> outValid);
    // R10
    valid_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load |=> !outValid);
    // R2
    rev_popcount_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && !strobe.orMode) |=> ($countones(result) == $countones($past(operand))));
    // R3
    orc_superset_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && strobe.orMode) |=> ((result & $past(operand)) == $past(operand)));
  end else begin : gComb
    assign result   = netOut;
    assign outValid = strobe.load;
  end

endmodule

// File: rtl/gbr_unit.sv
module gbr_unit
  import gbr_pkg::*;
#(
  parameter int DATA_W  = gbr_pkg::DATA_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSel,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  output logic [DATA_W-1:0] result,
  output logic              outValid
);

  localparam int CTRL_W = $clog2(DATA_W);

  gbrStrobe_t strobe;

  gbr_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .inValid (inValid),
    .opSel   (opSel),
    .ctrlAmt (operandB[CTRL_W-1:0]),
    .strobe  (strobe)
  );

  gbr_datapath #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operand  (operandA),
    .result   (result),
    .outValid (outValid)
  );

  // R1: the network sees exactly the low control bits of operandB
  ctrl_slice_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stageEn == operandB[CTRL_W-1:0]);

endmodule

// File: tb/sim_gbr_unit.sv
module sim_gbr_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        opSel;
  logic [31:0] operandA;
  logic [31:0] operandB;
  logic [31:0] result;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] expRes;

  always #5 clk = ~clk;

  gbr_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .operandA(operandA), .operandB(operandB), .result(result), .outValid(outValid)
  );

  // bit-index model: reverse moves bit i^k to i; OR-combine ORs every i^m, m subset of k
  function automatic logic [31:0] refModel(input bit orMode, input logic [31:0] a, input int k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (!orMode) r[i] = a[i ^ k];
      else begin
        r[i] = 1'b0;
        for (int m = 0; m < 32; m++) if ((m & ~k) == 0) r[i] = r[i] | a[i ^ m];
      end
    end
    return r;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a negedge, let one rising edge pass, sample at the next negedge
  task automatic step(input string tag, input bit op, input logic [31:0] a,
                      input logic [31:0] b, input bit v);
    opSel = op; operandA = a; operandB = b; inValid = v;
    @(posedge clk);
    @(negedge clk);
    if (v) expRes = refModel(op, a, int'(b[4:0]));
    check32(tag, result, expRes);
    check32({tag, " valid (R10)"}, {31'b0, outValid}, {31'b0, v});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; opSel = 1'b0; operandA = '0; operandB = '0;
    expRes = '0;
    repeat (3) @(negedge clk);
    // R10 reset state, even with a strobe present
    inValid = 1'b1; operandA = 32'hFFFF_FFFF;
    @(negedge clk);
    check32("R10 reset result", result, 32'h0);
    check32("R10 reset valid", {31'b0, outValid}, 32'h0);
    inValid = 1'b0;
    rstN = 1'b1;

    // R4 pass-through in both modes
    step("R4 rev zero ctrl", 1'b0, 32'hDEAD_BEEF, 32'h0, 1'b1);
    check32("R4 rev literal", result, 32'hDEAD_BEEF);
    step("R4 orc zero ctrl", 1'b1, 32'h1357_9BDF, 32'h0, 1'b1);
    check32("R4 orc literal", result, 32'h1357_9BDF);

    // R5..R8 named settings against literal values
    step("R5 full reverse", 1'b0, 32'h0000_0001, 32'h1F, 1'b1);
    check32("R5 literal", result, 32'h8000_0000);
    step("R5 full reverse pattern", 1'b0, 32'h1234_5678, 32'h1F, 1'b1);
    check32("R5 literal pattern", result, 32'h1E6A_2C48);
    step("R6 byte swap", 1'b0, 32'h1234_5678, 32'h18, 1'b1);
    check32("R6 literal", result, 32'h7856_3412);
    step("R7 byte orc", 1'b1, 32'h0010_0080, 32'h07, 1'b1);
    check32("R7 literal", result, 32'h00FF_00FF);
    step("R8 halfword orc", 1'b1, 32'h1234_0001, 32'h10, 1'b1);
    check32("R8 literal", result, 32'h1235_1235);

    // R1 upper control bits ignored
    step("R1 junk high bits ctrl0", 1'b0, 32'hCAFE_F00D, 32'hABCD_E000, 1'b1);
    check32("R1 literal", result, 32'hCAFE_F00D);
    step("R1 junk high bits reverse", 1'b0, 32'h1234_5678, 32'hFFFF_FFF8 | 32'h18, 1'b1);
    check32("R1 literal swap", result, 32'h7856_3412);

    // R9 hold: strobe low while inputs change
    step("R9 hold rev", 1'b0, 32'h0F0F_0F0F, 32'h1F, 1'b0);
    check32("R9 hold literal", result, 32'h7856_3412);
    step("R9 hold orc", 1'b1, 32'hFFFF_FFFF, 32'h07, 1'b0);

    // R2/R3 sweep of all control values, several operands each
    for (int k = 0; k < 32; k++) begin
      for (int n = 0; n < 4; n++) begin
        logic [31:0] a;
        logic [31:0] b;
        a = (n == 0) ? (32'h1 << k) : $urandom;
        b = {$urandom, 5'b0} | 32'(k);
        step("R2 reverse sweep", 1'b0, a, b, 1'b1);
        step("R3 orc sweep", 1'b1, a, b, 1'b1);
        if (n == 3) step("R9 idle gap", 1'b0, $urandom, $urandom, 1'b0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule